// File: doc/BRIEF.md
# IR Carrier Modulation Generator

This block produces the square-wave carrier that drives an infrared LED. A carrier period is a number of ticks. The first part of the period is the high (mark) phase and the rest is the low (space) phase. Both lengths are taken from a single configuration word. The tick comes from one of four sources, chosen by a 2-bit field in the control word:

- every system clock cycle;
- every third strobe of a crystal-derived enable;
- a 1 µs tick;
- a 10 µs tick.

The 1 µs and 10 µs ticks come from an internal prescaler. Its ratio, `CYC_PER_US`, is a parameter set from the reference clock frequency.

The control word holds a global enable and an init-high bit. Software sets init-high while it reprograms the block. A gate input from the symbol sequencer decides whether the carrier actually reaches the output; while the gate is low the period counter keeps running. A one-cycle boundary pulse marks the first cycle of every carrier period, and other logic can use it as a timebase.

New mark and space values are held in shadow registers. They are loaded only at a period boundary, or continuously while the block is disabled, so a rewrite during a period never produces a runt pulse. The shadow registers reset to 12/12, which is a 26 µs (about 38 kHz), 50 % carrier on the 1 µs tick.

Top module: `irc_carrier_gen`

## Requirements
- R1: After reset, with the control word all zero, `carrier_o` and `boundary_o` are both low.
- R2: `period_cfg_i[31:16]` holds the mark length minus one (M) and `period_cfg_i[15:0]` holds the space length minus one (S). With the tick select `ctrl_i[13:12]` = 0 (system clock), each period lasts M+S+2 cycles, and `carrier_o` is high for the first M+1 of them.
- R3: With tick select 1, one tick occurs per three `xtal_stb_i` strobes, so a period lasts 3·(M+S+2) strobe intervals, of which 3·(M+1) are high.
- R4: With tick select 2, a tick occurs every `CYC_PER_US` cycles. With tick select 3, a tick occurs every 10·`CYC_PER_US` cycles.
- R5: While `ctrl_i[0]` (enable) is clear, `carrier_o` is low (unless R6 applies) and no boundary pulse occurs. When enable is set, a new period starts at once with its high phase, using the configuration present just before enable was set.
- R6: While `ctrl_i[2]` (init-high) is set, `carrier_o` is high, whatever the enable and the gate.
- R7: While `gate_i` is low, `carrier_o` is low. The period counter keeps running, so boundary pulses keep their spacing.
- R8: `boundary_o` is high for exactly one cycle: the first cycle of each period. It is never high in two consecutive cycles. In that cycle `carrier_o` is high when the block is enabled, gated on and init-high is clear.
- R9: A configuration change during a period does not affect that period. The configuration present in the last cycle of a period is used for the next period. A change made in the boundary cycle therefore waits until the period after.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 32 | Control word: bit 0 enable, bit 2 init-high, bits 13:12 tick select |
| period_cfg_i | input | 2*HALF_W | Mark length minus one (upper half), space length minus one (lower half) |
| xtal_stb_i | input | 1 | One-cycle strobe per crystal clock edge, in the system clock domain |
| gate_i | input | 1 | Carrier gate from the symbol sequencer |
| carrier_o | output | 1 | Carrier output |
| boundary_o | output | 1 | One-cycle pulse in the first cycle of each carrier period |

## Verification
The interaction most likely to fail is a configuration rewrite that lands in the same cycle as a period wrap. The shadow load and the software write then meet at one clock edge.

The bench provokes this in two ways:
- It writes a new mark/space word in the last cycle of a period and expects the very next period to use it.
- It writes in the boundary cycle itself and expects one more old-length period first.

In both cases the measured high and total cycle counts are compared against M+1 and M+S+2. The same measurement, with the gate held low, shows that the boundary pulses keep their spacing while the carrier stays low.

// File: rtl/irc_pkg.sv
package irc_pkg;

   // Tick source select, decoded from the control word.
   typedef enum logic [1:0] {
      TICK_SYS   = 2'd0,
      TICK_XTAL3 = 2'd1,
      TICK_1US   = 2'd2,
      TICK_10US  = 2'd3
   } tick_sel_e;

   localparam int unsigned CTRL_W       = 32;
   localparam int unsigned CTRL_EN_BIT  = 0;
   localparam int unsigned CTRL_INI_BIT = 2;
   localparam int unsigned CTRL_SEL_LSB = 12;

   typedef struct packed {
      logic      en;
      logic      init_hi;
      tick_sel_e sel;
   } ctrl_t;

   function automatic ctrl_t decode_ctrl(input logic [CTRL_W-1:0] w);
      ctrl_t c;
      c.en      = w[CTRL_EN_BIT];
      c.init_hi = w[CTRL_INI_BIT];
      c.sel     = tick_sel_e'(w[CTRL_SEL_LSB +: 2]);
      return c;
   endfunction

endpackage

// File: rtl/irc_strobe_div.sv
// Divides a strobe stream by DIV: one output strobe per DIV input strobes.
module irc_strobe_div #(
   parameter int unsigned DIV = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic stb_i,
   output logic stb_o
);
   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

   if (DIV == 0) begin : g_bad_div
      $error("irc_strobe_div: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_pass
      logic unused_pass;
      assign unused_pass = clk_i ^ rst_ni;
      assign stb_o       = stb_i;
   end else begin : g_div
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            cnt_q <= '0;
         end else if (stb_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
         end
      end

      assign stb_o = stb_i & (cnt_q == LAST);
   end
endmodule

// File: rtl/irc_tick_prescaler.sv
// Free-running tick sources: the 1 us tick, the slow (10 us) tick and the crystal/3 tick.
module irc_tick_prescaler #(
   parameter int unsigned CYC_PER_US  = 200,
   parameter int unsigned US_PER_SLOW = 10,
   parameter int unsigned XTAL_DIV    = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic xtal_stb_i,
   output logic us_tick_o,
   output logic slow_tick_o,
   output logic xtal_tick_o
);
   irc_strobe_div #(.DIV(CYC_PER_US)) u_us_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .stb_i  (1'b1),
      .stb_o  (us_tick_o)
   );

   // The slow tick is cascaded from the 1 us tick.
   irc_strobe_div #(.DIV(US_PER_SLOW)) u_slow_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .stb_i  (us_tick_o),
      .stb_o  (slow_tick_o)
   );

   irc_strobe_div #(.DIV(XTAL_DIV)) u_xtal_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .stb_i  (xtal_stb_i),
      .stb_o  (xtal_tick_o)
   );
endmodule

// File: rtl/irc_tick_select.sv
// Picks the tick that advances the period counter.
module irc_tick_select
   import irc_pkg::*;
(
   input  tick_sel_e sel_i,
   input  logic      sys_tick_i,
   input  logic      xtal_tick_i,
   input  logic      us_tick_i,
   input  logic      slow_tick_i,
   output logic      tick_o
);
   always_comb begin
      unique case (sel_i)
         TICK_SYS:   tick_o = sys_tick_i;
         TICK_XTAL3: tick_o = xtal_tick_i;
         TICK_1US:   tick_o = us_tick_i;
         TICK_10US:  tick_o = slow_tick_i;
      endcase
   end
endmodule

// File: rtl/irc_period_engine.sv
// Period counter with shadowed mark/space lengths and a registered wrap pulse.
module irc_period_engine #(
   parameter int unsigned HALF_W    = 16,
   parameter int unsigned RST_MARK  = 12,
   parameter int unsigned RST_SPACE = 12
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              tick_i,
   input  logic [HALF_W-1:0] mark_i,
   input  logic [HALF_W-1:0] space_i,
   output logic              phase_hi_o,
   output logic              wrap_o,
   output logic [HALF_W-1:0] mark_sh_o,
   output logic [HALF_W-1:0] space_sh_o
);
   // One extra bit: mark+space+1 may reach 2^(HALF_W+1)-1.
   localparam int unsigned CNT_W = HALF_W + 1;

   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  last_w;
   logic [HALF_W-1:0] mark_q;
   logic [HALF_W-1:0] space_q;
   logic              wrap_q;
   logic              at_last;

   assign last_w  = CNT_W'(mark_q) + CNT_W'(space_q) + CNT_W'(1);
   assign at_last = (cnt_q == last_w);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         mark_q  <= HALF_W'(RST_MARK);
         space_q <= HALF_W'(RST_SPACE);
         wrap_q  <= 1'b0;
      end else if (!en_i) begin
         // Idle: hold the counter at period start and track the configuration.
         cnt_q   <= '0;
         mark_q  <= mark_i;
         space_q <= space_i;
         wrap_q  <= 1'b0;
      end else begin
         wrap_q <= tick_i & at_last;
         if (tick_i) begin
            if (at_last) begin
               cnt_q   <= '0;
               mark_q  <= mark_i;
               space_q <= space_i;
            end else begin
               cnt_q <= cnt_q + CNT_W'(1);
            end
         end
      end
   end

   assign phase_hi_o = (cnt_q <= CNT_W'(mark_q));
   assign wrap_o     = wrap_q;
   assign mark_sh_o  = mark_q;
   assign space_sh_o = space_q;
endmodule

// File: rtl/irc_carrier_gen.sv
module irc_carrier_gen
   import irc_pkg::*;
#(
   parameter int unsigned HALF_W      = 16,
   parameter int unsigned CYC_PER_US  = 200,
   parameter int unsigned US_PER_SLOW = 10,
   parameter int unsigned XTAL_DIV    = 3,
   parameter int unsigned RST_MARK    = 12,
   parameter int unsigned RST_SPACE   = 12
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [CTRL_W-1:0]   ctrl_i,
   input  logic [2*HALF_W-1:0] period_cfg_i,
   input  logic                xtal_stb_i,
   input  logic                gate_i,
   output logic                carrier_o,
   output logic                boundary_o
);
   if (HALF_W < 1 || HALF_W > 16) begin : g_bad_width
      $error("irc_carrier_gen: HALF_W must be in 1..16");
   end
   if (RST_MARK >= (1 << HALF_W) || RST_SPACE >= (1 << HALF_W)) begin : g_bad_rst
      $error("irc_carrier_gen: reset mark/space do not fit HALF_W");
   end

   ctrl_t             ctrl;
   logic              sel_tick;
   logic              us_tick;
   logic              slow_tick;
   logic              xtal_tick;
   logic              phase_hi;
   logic [HALF_W-1:0] shadow_mark;
   logic [HALF_W-1:0] shadow_space;
   logic              unused_ctrl;

   assign ctrl        = decode_ctrl(ctrl_i);
   assign unused_ctrl = ^{ctrl_i[CTRL_W-1:CTRL_SEL_LSB+2], ctrl_i[CTRL_SEL_LSB-1:CTRL_INI_BIT+1],
                          ctrl_i[CTRL_EN_BIT+1]};

   irc_tick_prescaler #(
      .CYC_PER_US  (CYC_PER_US),
      .US_PER_SLOW (US_PER_SLOW),
      .XTAL_DIV    (XTAL_DIV)
   ) u_presc (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .xtal_stb_i  (xtal_stb_i),
      .us_tick_o   (us_tick),
      .slow_tick_o (slow_tick),
      .xtal_tick_o (xtal_tick)
   );

   irc_tick_select u_sel (
      .sel_i       (ctrl.sel),
      .sys_tick_i  (1'b1),
      .xtal_tick_i (xtal_tick),
      .us_tick_i   (us_tick),
      .slow_tick_i (slow_tick),
      .tick_o      (sel_tick)
   );

   irc_period_engine #(
      .HALF_W    (HALF_W),
      .RST_MARK  (RST_MARK),
      .RST_SPACE (RST_SPACE)
   ) u_engine (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (ctrl.en),
      .tick_i     (sel_tick),
      .mark_i     (period_cfg_i[2*HALF_W-1:HALF_W]),
      .space_i    (period_cfg_i[HALF_W-1:0]),
      .phase_hi_o (phase_hi),
      .wrap_o     (boundary_o),
      .mark_sh_o  (shadow_mark),
      .space_sh_o (shadow_space)
   );

   // Init-high overrides everything; otherwise the enable and the gate mask the phase.
   assign carrier_o = ctrl.init_hi | (ctrl.en & gate_i & phase_hi);
endmodule

// File: rtl/irc_carrier_gen_chk.sv
module irc_carrier_gen_chk #(
   parameter int unsigned HALF_W = 16
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [31:0]       ctrl_i,
   input logic              gate_i,
   input logic              carrier_o,
   input logic              boundary_o,
   input logic [HALF_W-1:0] mark_sh,
   input logic [HALF_W-1:0] space_sh
);
   logic unused_chk;
   assign unused_chk = ^{ctrl_i[31:3], ctrl_i[1]};

   AST_INIT_FORCES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl_i[2] |-> carrier_o); // R6
   AST_GATE_FORCES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctrl_i[2] && !gate_i) |-> !carrier_o); // R7
   AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctrl_i[2] && !ctrl_i[0]) |-> !carrier_o); // R5
   AST_IDLE_NO_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctrl_i[0] |=> !boundary_o); // R5
   AST_BOUNDARY_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      boundary_o |=> !boundary_o); // R8
   AST_BOUNDARY_STARTS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (boundary_o && ctrl_i[0] && gate_i && !ctrl_i[2]) |-> carrier_o); // R8
   AST_SHADOW_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(ctrl_i[0]) && !boundary_o) |-> ($stable(mark_sh) && $stable(space_sh))); // R9
endmodule

bind irc_carrier_gen irc_carrier_gen_chk #(.HALF_W(HALF_W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .ctrl_i     (ctrl_i),
   .gate_i     (gate_i),
   .carrier_o  (carrier_o),
   .boundary_o (boundary_o),
   .mark_sh    (shadow_mark),
   .space_sh   (shadow_space)
);

// File: tb/irc_carrier_gen_tb_top.sv
`timescale 1ns/1ps
module irc_carrier_gen_tb_top;
   localparam int unsigned CPU = 3;   // cycles per microsecond tick in the bench
   localparam int unsigned XK  = 2;   // crystal strobe every XK cycles

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ctrl = '0;
   logic [31:0] cfg = '0;
   logic        xtal_stb = 1'b0;
   logic        gate = 1'b1;
   logic        carrier;
   logic        boundary;

   int checks = 0;
   int errors = 0;
   int xk_cnt = 0;

   always #2.5 clk = ~clk;

   irc_carrier_gen #(.CYC_PER_US(CPU)) dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .ctrl_i       (ctrl),
      .period_cfg_i (cfg),
      .xtal_stb_i   (xtal_stb),
      .gate_i       (gate),
      .carrier_o    (carrier),
      .boundary_o   (boundary)
   );

   // Free-running crystal strobe, one cycle high every XK cycles.
   always @(negedge clk) begin
      xk_cnt   <= (xk_cnt == XK - 1) ? 0 : xk_cnt + 1;
      xtal_stb <= (xk_cnt == XK - 1);
   end

   function automatic logic [31:0] mk_ctrl(input bit en, input bit ini, input bit [1:0] sel);
      logic [31:0] w;
      w        = '0;
      w[0]     = en;
      w[2]     = ini;
      w[13:12] = sel;
      return w;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic wait_boundary();
      for (int i = 0; i < 100000 && !boundary; i++) step();
   endtask

   // Counts from the current cycle up to (not including) the next boundary cycle.
   task automatic count_period(output int hi, output int tot);
      hi = 0;
      tot = 0;
      forever begin
         if (carrier) hi++;
         tot++;
         step();
         if (boundary || tot > 100000) break;
      end
   endtask

   task automatic run_sel(input string req, input bit [1:0] sel, input int m, input int s,
                          input int per_tick);
      int hi, tot;
      ctrl = mk_ctrl(0, 0, sel);
      cfg  = {16'(m), 16'(s)};
      step();
      ctrl = mk_ctrl(1, 0, sel);
      wait_boundary();
      count_period(hi, tot);
      chk({req, " high"}, hi, (m + 1) * per_tick);
      chk({req, " period"}, tot, (m + s + 2) * per_tick);
   endtask

   initial begin
      int hi, tot, cnt_hi, cnt_b;
      repeat (4) @(negedge clk);
      #1;
      rst_n = 1'b1;
      step();
      // R1: reset state
      chk("R1 carrier", int'(carrier), 0);
      chk("R1 boundary", int'(boundary), 0);

      // R2 / R5: exhaustive sweep on the system-clock tick, first and second period
      for (int m = 0; m < 4; m++) begin
         for (int s = 0; s < 4; s++) begin
            ctrl = mk_ctrl(0, 0, 2'd0);
            cfg  = {16'(m), 16'(s)};
            step();
            ctrl = mk_ctrl(1, 0, 2'd0);
            #0.1;
            chk("R5 starts high", int'(carrier), 1);
            count_period(hi, tot);
            chk("R2 first high", hi, m + 1);
            chk("R2 first period", tot, m + s + 2);
            count_period(hi, tot);
            chk("R2 high", hi, m + 1);
            chk("R2 period", tot, m + s + 2);
         end
      end

      // R3: crystal / 3
      run_sel("R3 (0,0)", 2'd1, 0, 0, 3 * XK);
      run_sel("R3 (1,2)", 2'd1, 1, 2, 3 * XK);
      run_sel("R3 (3,1)", 2'd1, 3, 1, 3 * XK);
      // R4: 1 us and 10 us ticks
      run_sel("R4 1us (0,0)", 2'd2, 0, 0, CPU);
      run_sel("R4 1us (2,1)", 2'd2, 2, 1, CPU);
      run_sel("R4 10us (0,1)", 2'd3, 0, 1, 10 * CPU);
      run_sel("R4 10us (2,1)", 2'd3, 2, 1, 10 * CPU);

      // R8: boundary cycle starts high and is a single cycle
      ctrl = mk_ctrl(0, 0, 2'd0);
      cfg  = {16'd2, 16'd1};
      step();
      ctrl = mk_ctrl(1, 0, 2'd0);
      wait_boundary();
      chk("R8 boundary seen", int'(boundary), 1);
      chk("R8 high at boundary", int'(carrier), 1);
      step();
      chk("R8 single-cycle pulse", int'(boundary), 0);

      // R7: gate low keeps the period, carrier low
      gate = 1'b0;
      wait_boundary();
      count_period(hi, tot);
      chk("R7 gated high", hi, 0);
      chk("R7 gated period", tot, 5);
      gate = 1'b1;

      // R6: init-high overrides enable and gate
      ctrl = mk_ctrl(0, 1, 2'd0);
      step();
      chk("R6 init while idle", int'(carrier), 1);
      ctrl = mk_ctrl(1, 1, 2'd0);
      gate = 1'b0;
      step();
      chk("R6 init while gated", int'(carrier), 1);
      gate = 1'b1;

      // R5: disabled -> no carrier, no boundary
      ctrl = mk_ctrl(0, 0, 2'd0);
      cnt_hi = 0;
      cnt_b  = 0;
      for (int i = 0; i < 30; i++) begin
         step();
         if (carrier) cnt_hi++;
         if (boundary) cnt_b++;
      end
      chk("R5 idle carrier", cnt_hi, 0);
      chk("R5 idle boundary", cnt_b, 0);

      // R9: configuration changes at and just before a wrap
      cfg = {16'd1, 16'd1};
      step();
      ctrl = mk_ctrl(1, 0, 2'd0);
      wait_boundary();
      cfg = {16'd3, 16'd0};            // written in the boundary cycle
      count_period(hi, tot);
      chk("R9 old period kept high", hi, 2);
      chk("R9 old period kept length", tot, 4);
      count_period(hi, tot);
      chk("R9 new high", hi, 4);
      chk("R9 new length", tot, 5);
      repeat (4) step();               // last cycle of the 5-cycle period
      cfg = {16'd1, 16'd1};
      step();
      chk("R9 boundary after last-cycle write", int'(boundary), 1);
      count_period(hi, tot);
      chk("R9 last-cycle write high", hi, 2);
      chk("R9 last-cycle write length", tot, 4);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule